// File: doc/BRIEF.md
# Up/Down Autoreload Timer

This block is a 16-bit timer with a 16-bit reload register. It advances by one on every clock in which its run bit is set and an external count-enable tick is high. The tick comes from a prescaler outside the block. A direction-enable control bit sets how the count moves. When it is clear, the timer counts upward only. When it is set, an external direction input picks the direction: high counts up and low counts down.

Counting up past the all-ones value is an overflow, and it loads the count from the reload register. Counting down has no zero boundary. Instead, an underflow happens when the count equals the reload register, and it loads the count with all ones. Both kinds of wrap set a sticky timer flag, toggle a wrap bit, and produce a one-cycle event pulse. The wrap bit therefore acts as a seventeenth counter bit. Software uses a single write port to load the count, the reload value and the control/flag register.

Top module: `updn_reload_timer`

## Requirements
- R1: A synchronous active-high reset clears the count, the reload value, the run bit, the direction-enable bit, the timer flag, the wrap bit and the event pulse.
- R2: The count changes only in a cycle where the run bit is 1 and the tick input is 1, or where a count write occurs. Otherwise it holds and no event pulse appears.
- R3: With direction-enable at 0, each enabled tick adds one to the count, whatever the level of the direction input.
- R4: In a cycle where counting up begins at all ones, the count is loaded from the reload value the register held before that edge. The timer flag is also set.
- R5: With direction-enable at 1, each enabled tick adds one when the direction input is 1. It subtracts one (modulo 2^16) when the direction input is 0, unless the count equals the reload value.
- R6: In a cycle where counting down begins with the count equal to the reload value, the count becomes FFFFh and the timer flag is set.
- R7: Every overflow or underflow inverts the wrap bit, unless a control write occurs in the same cycle.
- R8: The timer flag stays 1 until a control write stores 0 into it. A control write in the same cycle as a wrap overrides the flag and wrap-bit updates from that wrap.
- R9: A count write in the same cycle as an enabled tick wins: the count takes the written value and no wrap occurs.
- R10: The event pulse is 1 for exactly the cycle after each edge at which a wrap took place. It is registered, so it rises together with the flag.
- R11: Write selects: 0 loads the count, 1 loads the reload value, and 2 loads control. The control bits are bit 0 run, bit 1 direction-enable, bit 2 timer flag and bit 3 wrap bit. A written value is visible on the outputs after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle count-enable tick |
| dir_i | input | 1 | Direction input, 1 = up, 0 = down |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 count, 1 reload, 2 control |
| wr_data_i | input | 16 | Write data |
| count_o | output | 16 | Current count |
| reload_o | output | 16 | Reload value |
| run_o | output | 1 | Run bit |
| dir_en_o | output | 1 | Direction-enable bit |
| flag_o | output | 1 | Sticky timer flag |
| wrap_bit_o | output | 1 | Wrap bit (seventeenth count bit) |
| wrap_pulse_o | output | 1 | One-cycle wrap event pulse |

## Verification
The bench first runs in up-only mode with the direction input held low. This shows that the direction input is ignored when the direction-enable bit is clear. It then counts up to all ones and down to the reload value from counts just above it, which separates the two wrap rules from plain stepping. It also includes a down-count from a value below the reload value that passes through zero without an event. Writes placed on the same edge as a tick or a wrap separate which source has priority. A long random phase uses count values seeded near both boundaries and compares every output against the reference model on each clock.

// File: rtl/updn_timer_pkg.sv
package updn_timer_pkg;

    typedef enum logic [1:0] {
        SEL_COUNT  = 2'd0,
        SEL_RELOAD = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    localparam int CTL_RUN   = 0;
    localparam int CTL_DIREN = 1;
    localparam int CTL_FLAG  = 2;
    localparam int CTL_WRAP  = 3;
    localparam int CTL_BITS  = 4;

    typedef struct packed {
        logic run;
        logic dir_en;
    } ctrl_t;

    typedef struct packed {
        logic advance;
        logic up;
    } step_req_t;

    function automatic logic step_is_up(input logic dir_en, input logic dir_in);
        return !dir_en || dir_in;
    endfunction

endpackage

// File: rtl/updn_ctrl_reg.sv
module updn_ctrl_reg
    import updn_timer_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_ctrl,
    input  logic [CTL_BITS-1:0] wr_bits,
    output ctrl_t               ctrl_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q.run    <= wr_bits[CTL_RUN];
            ctrl_q.dir_en <= wr_bits[CTL_DIREN];
        end
    end
endmodule

// File: rtl/updn_count_path.sv
module updn_count_path
    import updn_timer_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  step_req_t        req,
    input  logic             wr_count,
    input  logic             wr_reload,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] count_q,
    output logic [WIDTH-1:0] reload_q,
    output logic             wrap
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);

    logic             at_top;
    logic             at_floor;
    logic [WIDTH-1:0] step_val;
    logic [WIDTH-1:0] count_d;

    always_comb begin
        at_top   = (count_q == ALL_ONES);
        at_floor = (count_q == reload_q);
        if (req.up) begin
            step_val = at_top ? reload_q : count_q + ONE;
        end else begin
            step_val = at_floor ? ALL_ONES : count_q - ONE;
        end
        wrap = req.advance && !wr_count && (req.up ? at_top : at_floor);
        if (wr_count) begin
            count_d = wr_data;
        end else if (req.advance) begin
            count_d = step_val;
        end else begin
            count_d = count_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q  <= '0;
            reload_q <= '0;
        end else begin
            count_q <= count_d;
            if (wr_reload) begin
                reload_q <= wr_data;
            end
        end
    end
endmodule

// File: rtl/updn_flag_reg.sv
module updn_flag_reg
    import updn_timer_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wrap,
    input  logic wr_ctrl,
    input  logic flag_wr,
    input  logic wrap_wr,
    output logic flag_q,
    output logic wrap_bit_q,
    output logic pulse_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q     <= 1'b0;
            wrap_bit_q <= 1'b0;
            pulse_q    <= 1'b0;
        end else begin
            pulse_q <= wrap;
            if (wr_ctrl) begin
                flag_q     <= flag_wr;
                wrap_bit_q <= wrap_wr;
            end else if (wrap) begin
                flag_q     <= 1'b1;
                wrap_bit_q <= !wrap_bit_q;
            end
        end
    end
endmodule

// File: rtl/updn_reload_timer.sv
module updn_reload_timer
    import updn_timer_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             dir_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [WIDTH-1:0] wr_data_i,
    output logic [WIDTH-1:0] count_o,
    output logic [WIDTH-1:0] reload_o,
    output logic             run_o,
    output logic             dir_en_o,
    output logic             flag_o,
    output logic             wrap_bit_o,
    output logic             wrap_pulse_o
);
    reg_sel_e  sel;
    logic      wr_count, wr_reload, wr_ctrl;
    ctrl_t     ctrl;
    step_req_t req;
    logic      wrap;

    always_comb begin
        sel         = reg_sel_e'(wr_sel_i);
        wr_count    = wr_en_i && (sel == SEL_COUNT);
        wr_reload   = wr_en_i && (sel == SEL_RELOAD);
        wr_ctrl     = wr_en_i && (sel == SEL_CTRL);
        req.advance = ctrl.run && tick_i;
        req.up      = step_is_up(ctrl.dir_en, dir_i);
    end

    updn_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_ctrl (wr_ctrl),
        .wr_bits (wr_data_i[CTL_BITS-1:0]),
        .ctrl_q  (ctrl)
    );

    updn_count_path #(.WIDTH(WIDTH)) u_path (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .wr_count  (wr_count),
        .wr_reload (wr_reload),
        .wr_data   (wr_data_i),
        .count_q   (count_o),
        .reload_q  (reload_o),
        .wrap      (wrap)
    );

    updn_flag_reg u_flags (
        .clk        (clk),
        .rst        (rst),
        .wrap       (wrap),
        .wr_ctrl    (wr_ctrl),
        .flag_wr    (wr_data_i[CTL_FLAG]),
        .wrap_wr    (wr_data_i[CTL_WRAP]),
        .flag_q     (flag_o),
        .wrap_bit_q (wrap_bit_o),
        .pulse_q    (wrap_pulse_o)
    );

    assign run_o    = ctrl.run;
    assign dir_en_o = ctrl.dir_en;
endmodule

// File: rtl/updn_reload_timer_chk.sv
module updn_reload_timer_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_i,
    input logic             dir_i,
    input logic             wr_en_i,
    input logic [1:0]       wr_sel_i,
    input logic [WIDTH-1:0] wr_data_i,
    input logic [WIDTH-1:0] count_o,
    input logic [WIDTH-1:0] reload_o,
    input logic             run_o,
    input logic             dir_en_o,
    input logic             flag_o,
    input logic             wrap_bit_o,
    input logic             wrap_pulse_o
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    // R2
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!(run_o && tick_i) && !wr_en_i) |=> ($stable(count_o) && !wrap_pulse_o));

    // R4
    a_r4_overflow: assert property (@(posedge clk) disable iff (rst)
        (run_o && tick_i && (!dir_en_o || dir_i) && count_o == ALL_ONES && !wr_en_i)
        |=> (count_o == $past(reload_o) && flag_o && wrap_pulse_o));

    // R5
    a_r5_down_step: assert property (@(posedge clk) disable iff (rst)
        (run_o && tick_i && dir_en_o && !dir_i && count_o != reload_o && !wr_en_i)
        |=> (count_o == $past(count_o) - WIDTH'(1)));

    // R6
    a_r6_underflow: assert property (@(posedge clk) disable iff (rst)
        (run_o && tick_i && dir_en_o && !dir_i && count_o == reload_o && !wr_en_i)
        |=> (count_o == ALL_ONES && flag_o && wrap_pulse_o));

    // R7
    a_r7_wrap_toggle: assert property (@(posedge clk) disable iff (rst)
        (wrap_pulse_o && !$past(wr_en_i)) |-> (wrap_bit_o != $past(wrap_bit_o)));

    // R8
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !wr_en_i) |=> flag_o);

    // R10
    a_r10_pulse_flag: assert property (@(posedge clk) disable iff (rst)
        (wrap_pulse_o && !$past(wr_en_i)) |-> flag_o);

    wire unused_ok = &{1'b0, wr_sel_i, wr_data_i};
endmodule

bind updn_reload_timer updn_reload_timer_chk #(.WIDTH(WIDTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .tick_i       (tick_i),
    .dir_i        (dir_i),
    .wr_en_i      (wr_en_i),
    .wr_sel_i     (wr_sel_i),
    .wr_data_i    (wr_data_i),
    .count_o      (count_o),
    .reload_o     (reload_o),
    .run_o        (run_o),
    .dir_en_o     (dir_en_o),
    .flag_o       (flag_o),
    .wrap_bit_o   (wrap_bit_o),
    .wrap_pulse_o (wrap_pulse_o)
);

// File: tb/updn_reload_timer_bench.sv
module updn_reload_timer_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_i = 1'b0;
    logic        dir_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_sel_i = 2'd3;
    logic [15:0] wr_data_i = '0;
    logic [15:0] count_o, reload_o;
    logic        run_o, dir_en_o, flag_o, wrap_bit_o, wrap_pulse_o;

    int checks = 0;
    int errors = 0;
    string cur_tag = "R1";

    // behavioural reference state
    int m_cnt = 0, m_rel = 0, m_run = 0, m_den = 0, m_flag = 0, m_wrap = 0, m_pulse = 0;

    always #(CLK_PERIOD/2) clk = !clk;

    updn_reload_timer u_updn_reload_timer (
        .clk(clk), .rst(rst), .tick_i(tick_i), .dir_i(dir_i),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .count_o(count_o), .reload_o(reload_o), .run_o(run_o), .dir_en_o(dir_en_o),
        .flag_o(flag_o), .wrap_bit_o(wrap_bit_o), .wrap_pulse_o(wrap_pulse_o)
    );

    always @(posedge clk) begin
        int nxt;
        int hit;
        if (rst) begin
            m_cnt = 0; m_rel = 0; m_run = 0; m_den = 0; m_flag = 0; m_wrap = 0; m_pulse = 0;
        end else begin
            nxt = m_cnt;
            hit = 0;
            if (m_run != 0 && tick_i) begin
                if (m_den == 0 || dir_i) begin
                    if (m_cnt == 65535) begin nxt = m_rel; hit = 1; end
                    else nxt = m_cnt + 1;
                end else begin
                    if (m_cnt == m_rel) begin nxt = 65535; hit = 1; end
                    else nxt = (m_cnt + 65535) % 65536;
                end
            end
            if (wr_en_i && wr_sel_i == 2'd0) begin nxt = int'(wr_data_i); hit = 0; end
            m_cnt = nxt;
            m_pulse = hit;
            if (hit != 0) begin m_flag = 1; m_wrap = 1 - m_wrap; end
            if (wr_en_i && wr_sel_i == 2'd1) m_rel = int'(wr_data_i);
            if (wr_en_i && wr_sel_i == 2'd2) begin
                m_run = int'(wr_data_i[0]); m_den = int'(wr_data_i[1]);
                m_flag = int'(wr_data_i[2]); m_wrap = int'(wr_data_i[3]);
            end
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("count", int'(count_o), m_cnt);
        chk("reload", int'(reload_o), m_rel);
        chk("run", int'(run_o), m_run);
        chk("dir_en", int'(dir_en_o), m_den);
        chk("flag", int'(flag_o), m_flag);
        chk("wrap_bit", int'(wrap_bit_o), m_wrap);
        chk("pulse", int'(wrap_pulse_o), m_pulse);
    endtask

    task automatic drive(input logic t, input logic d, input logic w,
                         input logic [1:0] s, input logic [15:0] dat);
        @(negedge clk);
        compare_all();
        tick_i = t; dir_i = d; wr_en_i = w; wr_sel_i = s; wr_data_i = dat;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 1'b0, 2'd3, 16'h0);
    endtask

    task automatic ticks(input int n, input logic d);
        for (int i = 0; i < n; i++) drive(1'b1, d, 1'b0, 2'd3, 16'h0);
    endtask

    task automatic wr(input logic [1:0] s, input logic [15:0] dat);
        drive(1'b0, 1'b0, 1'b1, s, dat);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL %s watchdog: actual hung expected done", cur_tag);
        finish_run();
    end

    initial begin
        cur_tag = "R1";
        idle(3);
        drive(1'b0, 1'b0, 1'b0, 2'd3, 16'h0);
        rst = 1'b0;
        idle(2);
        chk("reset count", int'(count_o), 0);

        cur_tag = "R11";
        wr(2'd1, 16'h1234);
        wr(2'd0, 16'hFFFD);
        wr(2'd2, 16'h0001);
        idle(1);

        cur_tag = "R3";
        ticks(2, 1'b0);
        cur_tag = "R4";
        ticks(1, 1'b0);
        idle(1);
        chk("overflow reload", int'(count_o), 16'h1234);
        cur_tag = "R10";
        idle(2);

        cur_tag = "R2";
        wr(2'd2, 16'h0004);
        ticks(3, 1'b1);
        wr(2'd2, 16'h0005);
        idle(3);

        cur_tag = "R8";
        wr(2'd2, 16'h0001);
        wr(2'd0, 16'hFFFF);
        drive(1'b1, 1'b0, 1'b1, 2'd2, 16'h0001);
        idle(2);

        cur_tag = "R5";
        wr(2'd2, 16'h0003);
        ticks(3, 1'b1);
        ticks(3, 1'b0);

        cur_tag = "R6";
        wr(2'd1, 16'h0010);
        wr(2'd0, 16'h0012);
        ticks(3, 1'b0);
        idle(1);
        chk("underflow load", int'(count_o), 16'hFFFF);
        cur_tag = "R7";
        wr(2'd0, 16'h0011);
        ticks(3, 1'b0);
        wr(2'd0, 16'h0001);
        ticks(4, 1'b0);

        cur_tag = "R9";
        drive(1'b1, 1'b1, 1'b1, 2'd0, 16'hFFFF);
        drive(1'b1, 1'b1, 1'b1, 2'd0, 16'h0042);
        idle(2);

        cur_tag = "R11";
        for (int i = 0; i < 3000; i++) begin
            int r;
            logic [15:0] v;
            r = $urandom_range(0, 99);
            if (r < 4) begin
                v = ($urandom_range(0, 1) != 0) ? 16'hFFFC + 16'($urandom_range(0, 3))
                                                : 16'h0010 + 16'($urandom_range(0, 3));
                drive(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'b1, 2'd0, v);
            end else if (r < 6) begin
                drive(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'b1, 2'd2,
                      16'($urandom_range(0, 15)) | 16'h0001);
            end else if (r < 7) begin
                drive(1'b1, 1'($urandom_range(0, 1)), 1'b1, 2'd1,
                      16'h0010 + 16'($urandom_range(0, 3)));
            end else begin
                drive(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)), 1'b0, 2'd3, 16'h0);
            end
        end
        idle(2);
        finish_run();
    end
endmodule